// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one table of 2-bit saturating counters. The table is indexed by the fetch address with its lowest bits dropped, XORed with a register holding recent branch outcomes. The address and the history interleave in the index, so one branch can train different counters for different recent paths. The spread across the table also reduces aliasing between branches.

The fetch stage presents a PC on the prediction port. In the same cycle it gets a direction, the table index used and the history value used. It keeps the index and history with the branch. When the branch resolves, the back end returns that index and history, the real outcome, and the direction that was predicted. The block trains the counter at the returned index. On a wrong guess it rebuilds the history from the returned value.

History is advanced speculatively: each prediction shifts its own guess into the register at once. The default table depth is 1024 entries (10 index bits). Setting `IDX_W` to 14 gives the 16K-entry configuration.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds binary 10 (weakly taken) and the history register is zero, so every PC predicts taken and `predHist` reads 0.
- R2: In the same cycle, `predIdx` equals `predPc[DROP+IDX_W-1:DROP]` XOR the history (zero-extended to `IDX_W`). `predTaken` is the upper bit of the counter at that index, where 1 means taken.
- R3: An update adds one to the counter at `updIdx` when `updTaken`=1 and subtracts one when `updTaken`=0. The counter stops at 11 and at 00 with no wraparound.
- R4: From a strong state (11 or 00), one opposite outcome leaves the predicted direction unchanged. A second consecutive opposite outcome flips it.
- R5: When `predValid`=1 and no mispredicted update arrives in that cycle, the next history is the old history shifted up by one, with `predTaken` entering at bit 0.
- R6: An update with `updTaken`≠`updPredTaken` loads the history with `{updHist[HIST_W-2:0], updTaken}` on the next cycle. This takes priority over a prediction shift in the same cycle.
- R7: A correctly predicted update, or a cycle with no prediction and no update, leaves the history unchanged.
- R8: An update writes only the entry named by `updIdx` as supplied. No other counter changes.
- R9: A prediction in the same cycle as an update to the same entry sees the value before the update. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | A branch is being predicted this cycle |
| predPc | input | PC_W | Fetch address of the branch |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIdx | output | IDX_W | Table index used, to be saved with the branch |
| predHist | output | HIST_W | History value used, to be saved with the branch |
| updValid | input | 1 | A resolved branch trains the table |
| updIdx | input | IDX_W | Index saved at prediction time |
| updHist | input | HIST_W | History saved at prediction time |
| updTaken | input | 1 | Actual outcome |
| updPredTaken | input | 1 | Direction that was predicted for it |

## Verification
A wrong history value shows up in `predHist` and `predIdx` in the very next cycle. A wrong counter value stays hidden until that entry is predicted again, and then only when its upper bit differs. For that reason the reference model compares all three outputs on every cycle. The directed phases walk a single entry through saturation and the two-step direction change, so that low-bit errors are driven into the visible bit. Random traffic on a small set of indices then re-reads each trained entry many times.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic histShift;    // shift predicted outcome into history
    logic histRestore;  // rebuild history from a resolved branch
    logic cntWrite;     // write a counter at the update index
    logic cntUp;        // direction of the counter step
  } gshStrobe_t;

  localparam logic [1:0] CNT_RESET = 2'b10;
  localparam logic [1:0] CNT_MAX   = 2'b11;
  localparam logic [1:0] CNT_MIN   = 2'b00;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == CNT_MAX) ? CNT_MAX : cur + 2'd1;
    else    res = (cur == CNT_MIN) ? CNT_MIN : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic       predValid,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updPredTaken,
  output gshStrobe_t strobe
);

  logic mispredict;

  always_comb begin
    mispredict         = updValid && (updTaken != updPredTaken);
    strobe.histRestore = mispredict;
    strobe.histShift   = predValid && !mispredict;
    strobe.cntWrite    = updValid;
    strobe.cntUp       = updTaken;
  end

endmodule

// File: rtl/gshare_datapath.sv
module gshare_datapath
  import gshare_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  gshStrobe_t        strobe,
  input  logic [IDX_W-1:0]  pcBits,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [HIST_W-1:0] updHist,
  input  logic              updTaken,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIdx,
  output logic [HIST_W-1:0] predHist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] histQ;
  logic [HIST_W-1:0] histD;
  logic [IDX_W-1:0]  histExt;
  logic [1:0]        cntArr [DEPTH];
  logic [1:0]        updCur;
  logic [1:0]        updNext;

  // Index hash: dropped-low-bit PC XOR history
  always_comb begin
    histExt   = IDX_W'(histQ);
    predIdx   = pcBits ^ histExt;
    predTaken = cntArr[predIdx][1];
    predHist  = histQ;
  end

  // History next state
  always_comb begin
    histD = histQ;
    if (strobe.histRestore)
      histD = {updHist[HIST_W-2:0], updTaken};
    else if (strobe.histShift)
      histD = {histQ[HIST_W-2:0], predTaken};
  end

  always_ff @(posedge clk) begin
    if (!rstN) histQ <= '0;
    else       histQ <= histD;
  end

  // Counter table
  always_comb begin
    updCur  = cntArr[updIdx];
    updNext = satStep(updCur, strobe.cntUp);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        cntArr[e] <= CNT_RESET;
      else if (strobe.cntWrite && (updIdx == IDX_W'(e)))
        cntArr[e] <= updNext;
    end
  end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int DROP   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIdx,
  output logic [HIST_W-1:0] predHist,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [HIST_W-1:0] updHist,
  input  logic              updTaken,
  input  logic              updPredTaken
);

  localparam int PC_HI = DROP + IDX_W;

  gshStrobe_t       strobe;
  logic [IDX_W-1:0] pcBits;
  logic             unusedPcBits;

  assign pcBits       = predPc[PC_HI-1:DROP];
  assign unusedPcBits = ^{predPc[PC_W-1:PC_HI], predPc[DROP-1:0]};

  gshare_ctrl u_ctrl (
    .predValid    (predValid),
    .updValid     (updValid),
    .updTaken     (updTaken),
    .updPredTaken (updPredTaken),
    .strobe       (strobe)
  );

  gshare_datapath #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pcBits    (pcBits),
    .updIdx    (updIdx),
    .updHist   (updHist),
    .updTaken  (updTaken),
    .predTaken (predTaken),
    .predIdx   (predIdx),
    .predHist  (predHist)
  );

endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              predValid,
  input logic              predTaken,
  input logic [IDX_W-1:0]  predIdx,
  input logic [HIST_W-1:0] predHist,
  input logic              updValid,
  input logic [IDX_W-1:0]  updIdx,
  input logic [HIST_W-1:0] updHist,
  input logic              updTaken,
  input logic              updPredTaken
);

  logic misUpd;
  assign misUpd = updValid && (updTaken != updPredTaken);

  // R6: restore from resolved branch
  a_r6_restore: assert property (@(posedge clk) disable iff (!rstN)
    misUpd |=> predHist == {$past(updHist[HIST_W-2:0]), $past(updTaken)});

  // R5: speculative shift of the guess
  a_r5_shift: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !misUpd) |=> predHist == {$past(predHist[HIST_W-2:0]), $past(predTaken)});

  // R7: history held otherwise
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!predValid && !misUpd) |=> $stable(predHist));

  // R3: a taken step on a taken-predicting entry keeps it taken
  a_r3_taken_stays: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && predValid && (predIdx == updIdx) && predTaken)
      |=> ((predIdx == $past(predIdx)) -> predTaken));

  // R3: a not-taken step on a not-taken entry keeps it not taken
  a_r3_nt_stays: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && predValid && (predIdx == updIdx) && !predTaken)
      |=> ((predIdx == $past(predIdx)) -> !predTaken));

endmodule

bind gshare_predictor gshare_checker #(
  .IDX_W  (IDX_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .predValid    (predValid),
  .predTaken    (predTaken),
  .predIdx      (predIdx),
  .predHist     (predHist),
  .updValid     (updValid),
  .updIdx       (updIdx),
  .updHist      (updHist),
  .updTaken     (updTaken),
  .updPredTaken (updPredTaken)
);

// File: tb/gshare_predictor_bench.sv
`timescale 1ns/1ps
module gshare_predictor_bench;

  localparam int PC_W = 32, IDX_W = 10, HIST_W = 10, DROP = 3;
  localparam int DEPTH = 1 << IDX_W;
  localparam int IMASK = DEPTH - 1;
  localparam int HMASK = (1 << HIST_W) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic predValid = 0;
  logic [PC_W-1:0] predPc = '0;
  logic predTaken;
  logic [IDX_W-1:0] predIdx;
  logic [HIST_W-1:0] predHist;
  logic updValid = 0;
  logic [IDX_W-1:0] updIdx = '0;
  logic [HIST_W-1:0] updHist = '0;
  logic updTaken = 0;
  logic updPredTaken = 0;

  always #5 clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .DROP(DROP)) u_gshare_predictor (
    .clk(clk), .rstN(rstN), .predValid(predValid), .predPc(predPc),
    .predTaken(predTaken), .predIdx(predIdx), .predHist(predHist),
    .updValid(updValid), .updIdx(updIdx), .updHist(updHist),
    .updTaken(updTaken), .updPredTaken(updPredTaken));

  int total = 0;
  int bad = 0;
  int mCnt [DEPTH];
  int mHist;
  bit done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare, advance model
  task automatic step(input string tag, input bit pv, input int pc,
                      input bit uv, input int ui, input int uh, input bit ut, input bit upt);
    int eIdx, eTaken;
    @(negedge clk);
    predValid = pv; predPc = pc; updValid = uv; updIdx = ui[IDX_W-1:0];
    updHist = uh[HIST_W-1:0]; updTaken = ut; updPredTaken = upt;
    #1;
    eIdx   = ((pc >>> DROP) & IMASK) ^ mHist;
    eTaken = (mCnt[eIdx] >= 2) ? 1 : 0;
    check(tag, "predHist", int'(predHist), mHist);
    check(tag, "predIdx", int'(predIdx), eIdx);
    check(tag, "predTaken", int'(predTaken), eTaken);
    if (uv) begin
      if (ut) mCnt[ui] = (mCnt[ui] == 3) ? 3 : mCnt[ui] + 1;
      else    mCnt[ui] = (mCnt[ui] == 0) ? 0 : mCnt[ui] - 1;
    end
    if (uv && (ut != upt)) mHist = ((uh << 1) | int'(ut)) & HMASK;
    else if (pv)           mHist = ((mHist << 1) | eTaken) & HMASK;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mCnt[i] = 2;
    mHist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset state predicts taken everywhere, history zero
    idle("R1");
    step("R1", 0, 32'h0000_1234, 0, 0, 0, 0, 0);
    step("R1", 0, 32'hFFFF_FFF8, 0, 0, 0, 0, 0);

    // R5: predictions shift the guess (taken) into history
    step("R5", 1, 32'h0000_0040, 0, 0, 0, 0, 0);
    step("R5", 1, 32'h0000_0080, 0, 0, 0, 0, 0);
    // R2: index now mixes nonzero history
    step("R2", 0, 32'h0000_0ABC, 0, 0, 0, 0, 0);
    // R7: correct update leaves history
    step("R7", 0, 32'h0000_0ABC, 1, 17, 0, 1, 1);
    idle("R7");

    // R3: saturate entry 5 up, then down
    for (int k = 0; k < 3; k++) step("R3", 0, 0, 1, 5, 0, 1, 1);
    // R4: from strong taken, first NT keeps taken, second flips
    step("R4", 0, 0, 1, 5, 0, 0, 0);
    step("R4", 0, 0, 1, 5, 0, 0, 0);
    for (int k = 0; k < 3; k++) step("R3", 0, 0, 1, 5, 0, 0, 0);
    step("R4", 0, 0, 1, 5, 0, 1, 1);
    step("R4", 0, 0, 1, 5, 0, 1, 1);
    // observe entry 5 through a PC aligned with current history
    step("R3", 0, ((5 ^ mHist) << DROP), 0, 0, 0, 0, 0);

    // R6: mispredict restore, overriding a same-cycle prediction
    step("R6", 1, 32'h0000_0100, 1, 9, 10'h2A5, 1, 0);
    step("R6", 1, 32'h0000_0100, 1, 9, 10'h155, 0, 1);
    idle("R6");

    // R8: update to one entry leaves neighbours
    step("R8", 0, 0, 1, 100, 0, 0, 0);
    step("R8", 0, 0, 1, 100, 0, 0, 0);
    step("R8", 0, ((101 ^ mHist) << DROP), 0, 0, 0, 0, 0);
    step("R8", 0, ((100 ^ mHist) << DROP), 0, 0, 0, 0, 0);

    // R9: same-cycle read of entry being written sees old value
    step("R9", 0, ((200 ^ mHist) << DROP), 1, 200, 0, 0, 1);
    step("R9", 0, ((200 ^ mHist) << DROP), 1, 200, 0, 0, 1);
    step("R9", 0, ((200 ^ mHist) << DROP), 0, 0, 0, 0, 0);

    // Random traffic on a small index set (R2 main path)
    for (int n = 0; n < 3000; n++) begin
      step("R2", 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)) << DROP,
           1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, HMASK)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule